// File: doc/BRIEF.md
# CAN bit timing and sampling unit

This unit builds the bit-time structure of a CAN node. Two clock-enable sources drive the engine, and a latched select bit picks one of them. A prescaler turns the chosen enable stream into time quanta. A quantum counter then walks each bit through four parts in turn: one sync quantum, the propagation segment, phase segment 1 and phase segment 2. The sample point is the boundary between the two phase segments. At that point the receive line is captured, either as one sample or as a majority vote over three samples.

The unit reports four things: each time quantum, the sample point, the sampled bit, and the start of each new bit, which is when the transmitter may drive its next bit. If the bus is idle, a falling edge on the receive line restarts the bit at the sync segment. A loop-back option feeds the transmit bit to the sampler in place of the external line.

Configuration is copied into the unit only while `run` is low. While `run` is high the timing stays fixed, whatever the configuration inputs do.

Top module: `can_bit_timer`

## Requirements
- R1: The engine enable is `osc_en` when the latched `cfg_clk_sel` is 0, and `sys_en` when it is 1.
- R2: `tq_tick` pulses once every (`cfg_presdiv` + 1) engine-enable cycles.
- R3: One bit lasts 1 + (`cfg_propseg`+1) + (`cfg_pseg1`+1) + (`cfg_pseg2`+1) quanta. `tx_stb` pulses, together with `tq_tick`, on the quantum tick that begins each new bit.
- R4: `sample_stb` pulses, together with `tq_tick`, on the tick that ends phase segment 1. The next `tx_stb` then follows (`cfg_pseg2`+1) quanta later. The two strobes never occur in the same cycle.
- R5: A `cfg_pseg2` value of 0 behaves exactly like 1.
- R6: With `cfg_triple` = 0, `rx_bit` takes the receive value present at the sample-point tick. `rx_bit` changes only in a cycle where `sample_stb` is high.
- R7: With `cfg_triple` = 1, `rx_bit` is the majority of the receive values at the last three quantum ticks: the sample-point tick and the two ticks before it.
- R8: With `cfg_loopback` = 1, `tx_bit` replaces `rx_in` as the sampled line, and `rx_in` has no effect on `rx_bit`.
- R9: With `bus_idle` = 1, a 1-to-0 change on the sampled line restarts the bit at quantum 0 with a cleared prescaler. The next `tx_stb` then comes exactly one bit time after that edge.
- R10: With `bus_idle` = 0, edges on the sampled line leave the bit timing untouched.
- R11: Configuration inputs are taken only while `run` = 0. While `run` = 0 the counters are cleared and `tq_tick` stays low. Changing the configuration while `run` = 1 leaves the bit period unchanged.
- R12: After reset, `tq_tick`, `sample_stb` and `tx_stb` are 0 and `rx_bit` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | 1 = timing active; 0 = frozen, configuration loading |
| osc_en | input | 1 | Oscillator-derived clock enable |
| sys_en | input | 1 | System-derived clock enable |
| cfg_clk_sel | input | 1 | Engine enable select (0 osc, 1 sys) |
| cfg_presdiv | input | PRES_W | Prescaler value minus one |
| cfg_propseg | input | SEG_W | Propagation segment length minus one |
| cfg_pseg1 | input | SEG_W | Phase segment 1 length minus one |
| cfg_pseg2 | input | SEG_W | Phase segment 2 length minus one (0 treated as 1) |
| cfg_triple | input | 1 | 1 = three-sample majority |
| cfg_loopback | input | 1 | 1 = sample tx_bit instead of rx_in |
| bus_idle | input | 1 | Permits hard synchronization |
| rx_in | input | 1 | External receive line |
| tx_bit | input | 1 | Transmit bit, used in loop-back |
| tq_tick | output | 1 | Time-quantum tick |
| sample_stb | output | 1 | Sample-point strobe |
| rx_bit | output | 1 | Sampled bit value |
| tx_stb | output | 1 | Start-of-bit (transmit point) strobe |

## Verification
The bench checks the bit period, the sample-to-start gap and the quantum spacing over several segment settings. These include the shortest bit, the longest bit, a half-rate oscillator enable and an illegal phase-2 value of zero. A design that mishandled the zero value would produce a bit one quantum short. Receive patterns are chosen so that single-sample and majority results differ: a vote built over the wrong quanta, or a vote missing altogether, returns the opposite bit. A falling edge is placed mid-bit twice. When the bus is idle, the next start-of-bit must move to exactly one bit after the edge. When it is not idle, the period must not change. Configuration is also changed while running; a unit that failed to hold its settings would show a shorter period.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    // Strobes registered at the top level, all from the same quantum tick.
    typedef struct packed {
        logic tq;
        logic smp;
        logic txp;
    } strobe_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          en,
    input  logic          restart,
    input  logic [PW-1:0] limit,
    output logic          tick
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    assign tick = run && !restart && en && (st_q.cnt == limit);

    always_comb begin
        st_d = st_q;
        if (!run || restart) begin
            st_d.cnt = '0;
        end else if (en) begin
            st_d.cnt = (st_q.cnt == limit) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cbt_quanta.sv
module cbt_quanta #(
    parameter int SW = 3,
    parameter int QW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic          restart,
    input  logic [SW-1:0] prop,
    input  logic [SW-1:0] ph1,
    input  logic [SW-1:0] ph2,
    output logic          at_sp,
    output logic          at_end
);
    typedef struct packed {
        logic [QW-1:0] q;
    } st_t;

    st_t st_d, st_q;
    logic [QW-1:0] sp_idx;
    logic [QW-1:0] last_idx;

    // Quantum 0 is sync; the sample point ends phase 1, the bit ends phase 2.
    assign sp_idx   = QW'(prop) + QW'(ph1) + QW'(2);
    assign last_idx = sp_idx + QW'(ph2) + QW'(1);
    assign at_sp    = tick && (st_q.q == sp_idx);
    assign at_end   = tick && (st_q.q == last_idx);

    always_comb begin
        st_d = st_q;
        if (!run || restart) begin
            st_d.q = '0;
        end else if (tick) begin
            st_d.q = at_end ? '0 : st_q.q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cbt_sampler.sv
module cbt_sampler
    import cbt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic at_sp,
    input  logic triple,
    input  logic rx,
    output logic bit_o
);
    typedef struct packed {
        logic [1:0] hist;
        logic       bitv;
    } st_t;

    st_t st_d, st_q;

    assign bit_o = st_q.bitv;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.hist = 2'b11;
        end else if (tick) begin
            st_d.hist = {st_q.hist[0], rx};
            if (at_sp) begin
                st_d.bitv = triple ? maj3(st_q.hist[1], st_q.hist[0], rx) : rx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{hist: 2'b11, bitv: 1'b1};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
    import cbt_pkg::*;
#(
    parameter int PRES_W = 8,
    parameter int SEG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              osc_en,
    input  logic              sys_en,
    input  logic              cfg_clk_sel,
    input  logic [PRES_W-1:0] cfg_presdiv,
    input  logic [SEG_W-1:0]  cfg_propseg,
    input  logic [SEG_W-1:0]  cfg_pseg1,
    input  logic [SEG_W-1:0]  cfg_pseg2,
    input  logic              cfg_triple,
    input  logic              cfg_loopback,
    input  logic              bus_idle,
    input  logic              rx_in,
    input  logic              tx_bit,
    output logic              tq_tick,
    output logic              sample_stb,
    output logic              rx_bit,
    output logic              tx_stb
);
    // Longest bit: sync plus three segments of 2**SEG_W quanta each.
    localparam int MAX_Q = 1 + 3 * (1 << SEG_W);
    localparam int QW    = $clog2(MAX_Q + 1);

    typedef struct packed {
        logic [PRES_W-1:0] pres;
        logic [SEG_W-1:0]  prop;
        logic [SEG_W-1:0]  ph1;
        logic [SEG_W-1:0]  ph2;
        logic              sel;
        logic              triple;
        logic              lpb;
    } cfg_t;

    typedef struct packed {
        cfg_t    cfg;
        logic    rx_prev;
        strobe_t stb;
    } st_t;

    st_t  st_d, st_q;
    logic eng_en;
    logic rx_sel;
    logic hsync;
    logic tick;
    logic at_sp;
    logic at_end;

    assign eng_en = st_q.cfg.sel ? sys_en : osc_en;
    assign rx_sel = st_q.cfg.lpb ? tx_bit : rx_in;
    assign hsync  = run && bus_idle && st_q.rx_prev && !rx_sel;

    cbt_prescaler #(.PW(PRES_W)) u_pres (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .en      (eng_en),
        .restart (hsync),
        .limit   (st_q.cfg.pres),
        .tick    (tick)
    );

    cbt_quanta #(.SW(SEG_W), .QW(QW)) u_quanta (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .restart (hsync),
        .prop    (st_q.cfg.prop),
        .ph1     (st_q.cfg.ph1),
        .ph2     (st_q.cfg.ph2),
        .at_sp   (at_sp),
        .at_end  (at_end)
    );

    cbt_sampler u_samp (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .tick   (tick),
        .at_sp  (at_sp),
        .triple (st_q.cfg.triple),
        .rx     (rx_sel),
        .bit_o  (rx_bit)
    );

    always_comb begin
        st_d         = st_q;
        st_d.rx_prev = rx_sel;
        st_d.stb.tq  = tick;
        st_d.stb.smp = at_sp;
        st_d.stb.txp = at_end;
        if (!run) begin
            st_d.cfg.pres   = cfg_presdiv;
            st_d.cfg.prop   = cfg_propseg;
            st_d.cfg.ph1    = cfg_pseg1;
            st_d.cfg.ph2    = (cfg_pseg2 == '0) ? SEG_W'(1) : cfg_pseg2;
            st_d.cfg.sel    = cfg_clk_sel;
            st_d.cfg.triple = cfg_triple;
            st_d.cfg.lpb    = cfg_loopback;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cfg.ph2 <= SEG_W'(1);
            st_q.cfg.sel <= 1'b1;
            st_q.rx_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tq_tick    = st_q.stb.tq;
    assign sample_stb = st_q.stb.smp;
    assign tx_stb     = st_q.stb.txp;
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
    input logic clk,
    input logic rst_n,
    input logic run,
    input logic tq_tick,
    input logic sample_stb,
    input logic tx_stb,
    input logic rx_bit
);
    p_halt_no_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tq_tick);

    p_txp_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> tq_tick);

    p_sp_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> tq_tick);

    p_sp_tx_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && tx_stb));

    p_sp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |=> !sample_stb);

    p_bit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(rx_bit));
endmodule

bind can_bit_timer cbt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .tq_tick    (tq_tick),
    .sample_stb (sample_stb),
    .tx_stb     (tx_stb),
    .rx_bit     (rx_bit)
);

// File: tb/sim_can_bit_timer.sv
`timescale 1ns/1ps
module sim_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run = 1'b0;
    logic       osc_en = 1'b0;
    logic       sys_en = 1'b1;
    logic       cfg_clk_sel = 1'b1;
    logic [7:0] cfg_presdiv = '0;
    logic [2:0] cfg_propseg = '0;
    logic [2:0] cfg_pseg1 = '0;
    logic [2:0] cfg_pseg2 = 3'd1;
    logic       cfg_triple = 1'b0;
    logic       cfg_loopback = 1'b0;
    logic       bus_idle = 1'b0;
    logic       rx_in = 1'b1;
    logic       tx_bit = 1'b1;
    logic       tq_tick, sample_stb, rx_bit, tx_stb;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always_ff @(posedge clk) begin
        cyc    <= cyc + 1;
        osc_en <= ~osc_en;
    end

    can_bit_timer u0 (.*);

    typedef struct packed {
        logic [7:0] pres;
        logic [2:0] prop;
        logic [2:0] s1;
        logic [2:0] s2;
        logic       sel;
        logic [7:0] e_bit;
        logic [7:0] e_gap;
        logic [7:0] e_tq;
    } vec_t;

    // Expected: bit = N*(pres+1)*rate, gap = (s2eff+1)*(pres+1)*rate, tq = (pres+1)*rate
    localparam vec_t VECS [5] = '{
        '{8'd0, 3'd0, 3'd0, 3'd1, 1'b1, 8'd5,  8'd2,  8'd1},
        '{8'd3, 3'd2, 3'd4, 3'd3, 1'b1, 8'd52, 8'd16, 8'd4},
        '{8'd1, 3'd1, 3'd2, 3'd0, 1'b1, 8'd16, 8'd4,  8'd2},
        '{8'd2, 3'd7, 3'd7, 3'd7, 1'b1, 8'd75, 8'd24, 8'd3},
        '{8'd1, 3'd0, 3'd1, 3'd2, 1'b0, 8'd28, 8'd12, 8'd4}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tx();
        @(negedge clk);
        while (!tx_stb) @(negedge clk);
    endtask

    task automatic wait_sp();
        @(negedge clk);
        while (!sample_stb) @(negedge clk);
    endtask

    task automatic wait_tq();
        @(negedge clk);
        while (!tq_tick) @(negedge clk);
    endtask

    task automatic configure(input logic [7:0] p, input logic [2:0] pr, input logic [2:0] a,
                             input logic [2:0] b, input logic sel, input logic tr, input logic lb);
        @(negedge clk);
        run = 1'b0;
        cfg_presdiv = p; cfg_propseg = pr; cfg_pseg1 = a; cfg_pseg2 = b;
        cfg_clk_sel = sel; cfg_triple = tr; cfg_loopback = lb;
        repeat (3) @(negedge clk);
        run = 1'b1;
    endtask

    task automatic pattern(input logic a, input logic b, input logic c,
                           input logic exp, input string req);
        wait_tx();
        rx_in = 1'b1;
        wait_tq(); rx_in = a;
        wait_tq(); rx_in = b;
        wait_tq(); rx_in = c;
        wait_sp();
        chk(req, rx_bit, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int t0, ts, t1, tq0;
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 tq_tick", tq_tick, 0);
        chk("R12 sample_stb", sample_stb, 0);
        chk("R12 tx_stb", tx_stb, 0);
        chk("R12 rx_bit", rx_bit, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4 R5: vector walk
        for (int i = 0; i < 5; i++) begin
            configure(VECS[i].pres, VECS[i].prop, VECS[i].s1, VECS[i].s2, VECS[i].sel, 1'b0, 1'b0);
            wait_tx(); t0 = cyc;
            wait_sp(); ts = cyc;
            wait_tx(); t1 = cyc;
            chk($sformatf("R3 bit period v%0d", i), t1 - t0, VECS[i].e_bit);
            chk($sformatf("R4 sample-to-start v%0d", i), t1 - ts, VECS[i].e_gap);
            wait_tq(); tq0 = cyc;
            wait_tq();
            chk($sformatf("R2 R1 quantum spacing v%0d", i), cyc - tq0, VECS[i].e_tq);
        end

        // R11: changes while running are ignored
        configure(8'd3, 3'd2, 3'd4, 3'd3, 1'b1, 1'b0, 1'b0);
        wait_tx();
        cfg_presdiv = 8'd0; cfg_pseg1 = 3'd0; cfg_clk_sel = 1'b0;
        t0 = cyc;
        wait_tx();
        chk("R11 period kept while running", cyc - t0, 52);
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        t1 = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            t1 += tq_tick;
        end
        chk("R11 no ticks while frozen", t1, 0);

        // R6 single sample, R7 majority (N=6, 4 cycles per quantum)
        configure(8'd3, 3'd0, 3'd1, 3'd1, 1'b1, 1'b0, 1'b0);
        pattern(1'b0, 1'b0, 1'b1, 1'b1, "R6 single takes last");
        pattern(1'b1, 1'b1, 1'b0, 1'b0, "R6 single takes last");
        configure(8'd3, 3'd0, 3'd1, 3'd1, 1'b1, 1'b1, 1'b0);
        pattern(1'b0, 1'b0, 1'b1, 1'b0, "R7 majority low");
        pattern(1'b1, 1'b1, 1'b0, 1'b1, "R7 majority high");
        pattern(1'b0, 1'b1, 1'b0, 1'b0, "R7 majority split");

        // R8 loop-back
        configure(8'd3, 3'd0, 3'd1, 3'd1, 1'b1, 1'b0, 1'b1);
        rx_in = 1'b0; tx_bit = 1'b1;
        wait_tx(); wait_sp();
        chk("R8 loopback high", rx_bit, 1);
        rx_in = 1'b1; tx_bit = 1'b0;
        wait_tx(); wait_sp();
        chk("R8 loopback low", rx_bit, 0);
        tx_bit = 1'b1;

        // R9 hard sync while idle
        configure(8'd3, 3'd0, 3'd1, 3'd1, 1'b1, 1'b0, 1'b0);
        rx_in = 1'b1; bus_idle = 1'b1;
        wait_tx(); wait_sp();
        @(negedge clk); @(negedge clk);
        t0 = cyc;
        rx_in = 1'b0;
        wait_tx();
        chk("R9 restart after edge", cyc - t0, 25);

        // R10 edge ignored when not idle
        bus_idle = 1'b0;
        rx_in = 1'b1;
        wait_tx(); t0 = cyc;
        wait_sp();
        @(negedge clk); @(negedge clk);
        rx_in = 1'b0;
        wait_tx();
        chk("R10 period unchanged", cyc - t0, 24);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule